// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock sent to an SD card from one of two sources: the system base clock, or a multiplied clock that is modelled here as a one-cycle enable (`mult_tick`) qualified against the base clock. A single 16-bit control word, written and read through a plain write strobe and a read bus, holds a 10-bit divisor, the generator mode, the card-clock enable and an internal-clock enable. The block sets the internal-clock-ready bit after a settling time. The output is gated so that it always comes to rest at logic low.

In divided mode a divisor D of 1 or more gives a square wave whose period is 2·D base cycles. A divisor of 0 passes the base clock straight through, gated by a flop clocked on the falling edge. In programmable mode the output gives one base-cycle-wide high pulse for every D+1 multiplied-clock ticks. A divisor written while the clock runs is held back until the output has stopped. When the preset select input is high, the divisor and the mode follow preset inputs instead of register writes. When the card is removed, hardware drops the card-clock enable.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000. It is laid out as: bits 15:8 divisor[7:0], bits 7:6 divisor[9:8], bit 5 mode (1 = programmable), bit 2 card-clock enable, bit 1 internal-clock-ready (read only), bit 0 internal-clock enable. Bits 4:3 always read 0, and write data in bits 4:3 and bit 1 is discarded.
- R2: In divided mode with divisor D ≥ 1, the output is high for D base cycles and then low for D base cycles. The output first goes high on the first base-clock rising edge at which the clock is allowed to run.
- R3: In divided mode with divisor 0, the output equals the base clock for as long as the clock runs.
- R4: In programmable mode with divisor D, the output is high for exactly one base cycle after every D+1 multiplied-clock ticks and is low at all other times.
- R5: While `mult_cap` is 0, writes to the mode bit have no effect and the mode bit reads 0.
- R6: While `card_present` is 0, the card-clock enable reads 0 from the next cycle on, writes of 1 to it are lost, and the output stays low.
- R7: Internal-clock-ready reads 1 exactly STABLE_CYCLES base cycles after the internal-clock enable is written to 1. It reads 0 in the same cycle that the internal-clock enable reads 0.
- R8: The output runs only while both the card-clock enable and internal-clock-ready are 1. A card-clock enable written before the clock is ready is stored, and the clock starts once the ready bit sets.
- R9: When the clock is stopped, the output finishes the high phase it is in and then stays low. In bypass mode the output stops at a falling edge of the base clock.
- R10: A new divisor or mode takes effect only after the output has stopped. While the clock runs, the old frequency is kept.
- R11: While `preset_sel` is 1, the divisor and mode follow `preset_div` and `preset_prog` one cycle later, and register writes to those fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data |
| card_present | input | 1 | High while a card is inserted |
| mult_cap | input | 1 | Programmable mode is available |
| preset_sel | input | 1 | Divisor and mode come from the preset inputs |
| preset_div | input | 10 | Preset divisor |
| preset_prog | input | 1 | Preset mode (1 = programmable) |
| mult_tick | input | 1 | One-cycle tick of the multiplied clock |
| sd_clk | output | 1 | Clock to the card |

## Verification
The bench builds the block with STABLE_CYCLES set to 5, so the ready delay can be checked at its exact cycle and repeated around enable toggles without long waits. The tick rate of the multiplied clock is changed during the run, which shows that the programmable period is counted in ticks and not in base cycles. Divisors range from 0 (bypass) and small values up to 258, which sets divisor bit 8 and so checks the upper-bit field position. The output is compared with the reference model in both halves of every base cycle, which exposes bypass gating and stop-low behaviour at the falling edge.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   localparam int CW_W   = 16;
   localparam int DIV_W  = 10;

   // Bit positions of the control word
   localparam int B_INTEN = 0;
   localparam int B_READY = 1;
   localparam int B_SDEN  = 2;
   localparam int B_PROG  = 5;
   localparam int B_DHI   = 6;
   localparam int B_DLO   = 8;

   typedef struct packed {
      logic             prog;
      logic [DIV_W-1:0] div;
   } clk_cfg_t;

   function automatic logic [CW_W-1:0] pack_word(input clk_cfg_t c,
                                                 input logic sden,
                                                 input logic ready,
                                                 input logic inten);
      logic [CW_W-1:0] w;
      w = '0;
      w[B_DLO +: 8]  = c.div[7:0];
      w[B_DHI +: 2]  = c.div[DIV_W-1:8];
      w[B_PROG]      = c.prog;
      w[B_SDEN]      = sden;
      w[B_READY]     = ready;
      w[B_INTEN]     = inten;
      return w;
   endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
   import sdclk_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CW_W-1:0] wdata,
   input  logic            card_present,
   input  logic            mult_cap,
   input  logic            preset_sel,
   input  clk_cfg_t        preset_cfg,
   input  logic            ready,
   output clk_cfg_t        cfg,
   output logic            sden,
   output logic            inten,
   output logic [CW_W-1:0] rdata
);

   logic [DIV_W-1:0] div_q;
   logic             prog_q;
   logic             sden_q;
   logic             inten_q;
   logic             unused_wbits;

   assign unused_wbits = ^{wdata[4:3], wdata[B_READY]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         prog_q  <= 1'b0;
         sden_q  <= 1'b0;
         inten_q <= 1'b0;
      end else begin
         if (!card_present)
            sden_q <= 1'b0;
         else if (we)
            sden_q <= wdata[B_SDEN];

         if (we)
            inten_q <= wdata[B_INTEN];

         if (preset_sel) begin
            div_q  <= preset_cfg.div;
            prog_q <= preset_cfg.prog & mult_cap;
         end else if (we) begin
            div_q <= {wdata[B_DHI +: 2], wdata[B_DLO +: 8]};
            if (mult_cap)
               prog_q <= wdata[B_PROG];
         end
      end
   end

   assign cfg.div  = div_q;
   assign cfg.prog = prog_q & mult_cap;
   assign sden     = sden_q;
   assign inten    = inten_q;
   assign rdata    = pack_word(cfg, sden_q, ready, inten_q);

endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
   parameter int STABLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inten,
   output logic ready
);

   generate
      if (STABLE_CYCLES == 0) begin : g_instant
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign ready = inten;
      end else begin : g_count
         localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!inten)
               cnt_q <= '0;
            else if (cnt_q != LAST)
               cnt_q <= cnt_q + 1'b1;
         end

         assign ready = inten && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
   import sdclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  clk_cfg_t         cfg,
   input  logic             mult_tick,
   output logic             sd_clk,
   output logic             active,
   output logic             level,
   output logic [DIV_W-1:0] held_div
);

   clk_cfg_t         act_q;
   logic [DIV_W-1:0] cnt_q;
   logic             running_q;
   logic             out_q;
   logic             gate_q;
   logic             bypass;

   assign bypass = !act_q.prog && (act_q.div == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= '0;
         cnt_q     <= '0;
         running_q <= 1'b0;
         out_q     <= 1'b0;
      end else if (!running_q) begin
         // stopped: latch the new setting, start when allowed
         act_q     <= cfg;
         cnt_q     <= '0;
         running_q <= run;
         out_q     <= run && !cfg.prog && (cfg.div != '0);
      end else if (act_q.prog) begin
         out_q <= 1'b0;
         if (!run) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
         end else if (mult_tick) begin
            if (cnt_q == act_q.div) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else if (bypass) begin
         if (!run)
            running_q <= 1'b0;
      end else begin
         if (!run && !out_q) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
         end else if (cnt_q == act_q.div - 1'b1) begin
            cnt_q <= '0;
            out_q <= !out_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // gate for the undivided path changes only while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         gate_q <= 1'b0;
      else
         gate_q <= running_q && bypass;
   end

   assign sd_clk   = bypass ? (clk & gate_q) : out_q;
   assign active   = running_q;
   assign level    = out_q;
   assign held_div = act_q.div;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int STABLE_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CW_W-1:0]  cfg_wdata,
   output logic [CW_W-1:0]  cfg_rdata,
   input  logic             card_present,
   input  logic             mult_cap,
   input  logic             preset_sel,
   input  logic [DIV_W-1:0] preset_div,
   input  logic             preset_prog,
   input  logic             mult_tick,
   output logic             sd_clk
);

   generate
      if (STABLE_CYCLES < 0) begin : g_bad_settle
         $error("sdclk_gen: STABLE_CYCLES must not be negative");
      end
      if (DIV_W != 10 || CW_W != 16) begin : g_bad_layout
         $error("sdclk_gen: control word layout needs a 10-bit divisor in 16 bits");
      end
   endgenerate

   clk_cfg_t         preset_cfg;
   clk_cfg_t         cfg;
   logic             sden;
   logic             inten;
   logic             ready;
   logic             run;
   logic             div_active;
   logic             div_level;
   logic [DIV_W-1:0] div_held;

   assign preset_cfg.div  = preset_div;
   assign preset_cfg.prog = preset_prog;

   sdclk_ctrl_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (cfg_we),
      .wdata        (cfg_wdata),
      .card_present (card_present),
      .mult_cap     (mult_cap),
      .preset_sel   (preset_sel),
      .preset_cfg   (preset_cfg),
      .ready        (ready),
      .cfg          (cfg),
      .sden         (sden),
      .inten        (inten),
      .rdata        (cfg_rdata)
   );

   sdclk_settle #(.STABLE_CYCLES(STABLE_CYCLES)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .inten (inten),
      .ready (ready)
   );

   assign run = sden && ready;

   sdclk_divider u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .cfg       (cfg),
      .mult_tick (mult_tick),
      .sd_clk    (sd_clk),
      .active    (div_active),
      .level     (div_level),
      .held_div  (div_held)
   );

endmodule

// File: rtl/sdclk_chk.sv
module sdclk_chk
   import sdclk_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             card_present,
   input logic             mult_cap,
   input logic [CW_W-1:0]  cfg_rdata,
   input logic             run,
   input logic             div_active,
   input logic             div_level,
   input logic [DIV_W-1:0] div_held
);

   AST_CARD_GONE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !card_present |=> !cfg_rdata[B_SDEN]); // R6

   AST_NOCAP_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mult_cap |-> !cfg_rdata[B_PROG]); // R5

   AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[B_READY] |-> cfg_rdata[B_INTEN]); // R7

   AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_level) |-> $past(run)); // R8

   AST_DIV_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (div_active && $past(div_active)) |-> $stable(div_held)); // R10

endmodule

bind sdclk_gen sdclk_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .card_present (card_present),
   .mult_cap     (mult_cap),
   .cfg_rdata    (cfg_rdata),
   .run          (run),
   .div_active   (div_active),
   .div_level    (div_level),
   .div_held     (div_held)
);

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

   localparam int CLK_PERIOD = 10;
   localparam int SC         = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        card_present = 1'b1;
   logic        mult_cap = 1'b1;
   logic        preset_sel = 1'b0;
   logic [9:0]  preset_div = '0;
   logic        preset_prog = 1'b0;
   logic        mult_tick = 1'b0;
   logic        sd_clk;

   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   bit    compare_on = 1'b0;
   string cur_req = "R1";
   int    tick_every = 1;
   int    tick_n = 0;

   // reference model state
   int m_div = 0, m_prog = 0, m_sden = 0, m_inten = 0, m_scnt = 0;
   int m_run = 0, m_adiv = 0, m_aprog = 0, m_cnt = 0, m_q = 0, m_gate = 0;

   sdclk_gen #(.STABLE_CYCLES(SC)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .card_present(card_present), .mult_cap(mult_cap),
      .preset_sel(preset_sel), .preset_div(preset_div), .preset_prog(preset_prog),
      .mult_tick(mult_tick), .sd_clk(sd_clk)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      #1;
      tick_n = tick_n + 1;
      mult_tick = ((tick_n % tick_every) == 0);
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d (0x%0h) exp=%0d (0x%0h) t=%0t", req, act, act, exp, exp, $time);
      end
   endtask

   // model update on each rising edge, from values held before the edge
   always @(posedge clk) begin
      int rdy, rn, eprog, byp;
      int n_div, n_prog, n_sden, n_inten, n_scnt;
      if (!rst_n) begin
         m_div = 0; m_prog = 0; m_sden = 0; m_inten = 0; m_scnt = 0;
         m_run = 0; m_adiv = 0; m_aprog = 0; m_cnt = 0; m_q = 0;
      end else begin
         rdy   = (m_inten != 0 && m_scnt == SC);
         rn    = (m_sden != 0 && rdy != 0);
         eprog = m_prog & int'(mult_cap);
         n_sden  = !card_present ? 0 : (cfg_we ? int'(cfg_wdata[2]) : m_sden);
         n_inten = cfg_we ? int'(cfg_wdata[0]) : m_inten;
         n_div = m_div; n_prog = m_prog;
         if (preset_sel) begin
            n_div = int'(preset_div); n_prog = int'(preset_prog & mult_cap);
         end else if (cfg_we) begin
            n_div = int'(cfg_wdata[7:6]) * 256 + int'(cfg_wdata[15:8]);
            if (mult_cap) n_prog = int'(cfg_wdata[5]);
         end
         n_scnt = (m_inten == 0) ? 0 : ((m_scnt < SC) ? m_scnt + 1 : m_scnt);
         byp = (m_aprog == 0 && m_adiv == 0);
         if (m_run == 0) begin
            m_adiv = m_div; m_aprog = eprog; m_cnt = 0;
            m_run = rn;
            m_q = (rn != 0 && eprog == 0 && m_div != 0);
         end else if (m_aprog != 0) begin
            m_q = 0;
            if (!rn) begin m_run = 0; m_cnt = 0; end
            else if (mult_tick) begin
               if (m_cnt == m_adiv) begin m_cnt = 0; m_q = 1; end
               else m_cnt = m_cnt + 1;
            end
         end else if (byp != 0) begin
            if (!rn) m_run = 0;
         end else begin
            if (!rn && m_q == 0) begin m_run = 0; m_cnt = 0; end
            else if (m_cnt == m_adiv - 1) begin m_cnt = 0; m_q = 1 - m_q; end
            else m_cnt = m_cnt + 1;
         end
         m_div = n_div; m_prog = n_prog; m_sden = n_sden;
         m_inten = n_inten; m_scnt = n_scnt;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) m_gate = 0;
      else m_gate = (m_run != 0 && m_aprog == 0 && m_adiv == 0);
   end

   // compare in both halves of every cycle
   always @(clk) begin
      int e_clk, e_rd, rdy;
      #3;
      if (compare_on && rst_n) begin
         e_clk = (m_aprog == 0 && m_adiv == 0) ? (int'(clk) & m_gate) : m_q;
         chk({cur_req, " sd_clk"}, int'(sd_clk), e_clk);
         if (clk) begin
            rdy  = (m_inten != 0 && m_scnt == SC);
            e_rd = (m_div % 256) * 256 + (m_div / 256) * 64 + (m_prog & int'(mult_cap)) * 32
                   + m_sden * 4 + rdy * 2 + m_inten;
            chk({cur_req, " rdata"}, int'(cfg_rdata), e_rd);
         end
      end
   end

   task automatic wr(input logic [15:0] v);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_wdata = v;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // rising edges are counted in half cycles; period returned in base cycles
   task automatic period(output int per);
      int first;
      logic prev;
      per = -1; first = -1; prev = 1'b1;
      for (int i = 0; i < 8000; i++) begin
         @(clk); #3;
         if (sd_clk && !prev) begin
            if (first < 0) first = i;
            else begin per = (i - first) / 2; break; end
         end
         prev = sd_clk;
      end
      cycles(1);
   endtask

   task automatic low_for(input string req, input int n);
      int highs;
      highs = 0;
      for (int i = 0; i < 2 * n; i++) begin
         @(clk); #3;
         if (sd_clk) highs++;
      end
      chk(req, highs, 0);
      cycles(1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int p;
      cycles(3);
      chk("R1 reset word", int'(cfg_rdata), 0);
      rst_n = 1'b1;
      compare_on = 1'b1;
      cycles(2);

      // R1 layout, R7 ready timing
      cur_req = "R1";
      wr(16'hFFFF);
      chk("R1 readback", int'(cfg_rdata), 16'hFFE5);
      cur_req = "R7";
      cycles(SC - 1);
      chk("R7 ready too early", int'(cfg_rdata[1]), 0);
      cycles(1);
      chk("R7 ready on time", int'(cfg_rdata[1]), 1);
      wr(16'h0001);
      cycles(4);

      // R2 divided mode
      cur_req = "R2";
      wr(16'h0305);
      period(p);
      chk("R2 period D=3", p, 6);

      // R10 divisor held while running
      cur_req = "R10";
      wr(16'h0505);
      period(p);
      chk("R10 old period kept", p, 6);
      cur_req = "R9";
      wr(16'h0501);
      cycles(8);
      low_for("R9 stopped low", 10);
      cur_req = "R10";
      wr(16'h0505);
      period(p);
      chk("R10 new period after stop", p, 10);
      wr(16'h0501);
      cycles(12);

      // R2 upper divisor bits: D = 0x102
      cur_req = "R2";
      wr(16'h0245);
      period(p);
      chk("R2 period D=258", p, 516);
      wr(16'h0001);
      cycles(600);

      // R3 bypass
      cur_req = "R3";
      wr(16'h0005);
      period(p);
      chk("R3 bypass period", p, 1);
      cur_req = "R9";
      wr(16'h0001);
      cycles(2);
      low_for("R9 bypass stopped low", 6);

      // R4 programmable
      cur_req = "R4";
      tick_every = 1;
      wr(16'h0225);
      period(p);
      chk("R4 period D=2 tick=1", p, 3);
      tick_every = 2;
      cycles(12);
      period(p);
      chk("R4 period D=2 tick=2", p, 6);
      wr(16'h0001);
      tick_every = 1;
      cycles(6);

      // R5 mode bit without capability
      cur_req = "R5";
      mult_cap = 1'b0;
      wr(16'h0021);
      chk("R5 mode reads 0", int'(cfg_rdata[5]), 0);
      mult_cap = 1'b1;
      cycles(1);
      chk("R5 write was ignored", int'(cfg_rdata[5]), 0);

      // R6 card removal
      cur_req = "R6";
      wr(16'h0305);
      cycles(9);
      card_present = 1'b0;
      cycles(1);
      chk("R6 enable cleared", int'(cfg_rdata[2]), 0);
      wr(16'h0305);
      chk("R6 write of 1 lost", int'(cfg_rdata[2]), 0);
      cycles(6);
      low_for("R6 clock held low", 10);
      card_present = 1'b1;
      cycles(2);

      // R8 enable before ready
      cur_req = "R8";
      wr(16'h0304);
      chk("R7 ready clears with enable", int'(cfg_rdata[1]), 0);
      chk("R8 card enable stored", int'(cfg_rdata[2]), 1);
      low_for("R8 no clock before ready", 10);
      wr(16'h0305);
      cycles(SC);
      period(p);
      chk("R8 clock after ready", p, 6);

      // R11 preset override
      cur_req = "R11";
      preset_div = 10'd7;
      preset_prog = 1'b0;
      preset_sel = 1'b1;
      cycles(1);
      chk("R11 preset divisor", int'(cfg_rdata[15:6]), 7 * 4);
      wr(16'hFF01);
      cycles(10);
      chk("R11 write ignored", int'(cfg_rdata[15:6]), 7 * 4);
      wr(16'hFF05);
      period(p);
      chk("R11 preset period", p, 14);
      preset_sel = 1'b0;
      wr(16'h0001);
      cycles(20);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule